// File: doc/BRIEF.md
# Bulk Multi-Stream Line Prefetcher

This block sits next to a processor's load/store path and fetches whole arrays into the cache on its own. Software first describes up to four streams. Each stream has a byte base address and a length counted in 16-byte cache lines. Software then sets a wakeup count and issues a start pulse. While running, the engine pushes one line request per cycle into an external request buffer whenever that buffer has room. It visits the streams with work left in a fixed rotating order, so the buffer stays filled and the memory data bus never idles.

Once the programmed number of requests has been accepted, the engine raises a level interrupt that wakes the sleeping processor. When every stream has been fully requested, it stops and drops its busy flag. The buffer, the cache and the memory timing lie outside this block. The memory returns a line after a 12-cycle request latency and then one 32-bit word every 3 cycles, so the buffer drains one line every 12 cycles.

Top module: `bulk_prefetch_engine`

## Requirements
- R1: After reset, `req_valid`, `busy` and `wake_irq` are 0.
- R2: Each line request of a stream carries address `base + k*16`, where k counts that stream's earlier requests since it was last configured, starting at 0. `req_stream` gives the stream number.
- R3: While `busy` is 1 and `buf_full` is 0, `req_valid` is 1. A request is accepted in every cycle where `req_valid` is 1, and `req_valid` is never 1 while `buf_full` is 1.
- R4: After start, service begins at stream 0. It then moves to the next stream number, wrapping to 0 after the last stream. Each stream gets one request per turn, and a stream with no lines left is skipped.
- R5: A cycle with `buf_full` high issues nothing and keeps the rotation position, so the request order is the same as with no stalls.
- R6: `busy` rises at the edge that takes `start` only if some stream has lines to fetch. It falls at the edge that accepts the last line, and no request follows until the next start.
- R7: `wake_irq` rises at the clock edge that accepts the w-th request counted since the wakeup count w was last written. A written count of 0 never fires. A request accepted at the same edge as a wakeup write is not counted.
- R8: `wake_irq` stays 1 until an `irq_clr` pulse clears it. Writing a new wakeup count while running restarts the count.
- R9: Stream configuration writes made while `busy` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Stream configuration write strobe |
| cfg_idx | input | 2 | Stream number to configure |
| cfg_base | input | 32 | Stream byte base address |
| cfg_lines | input | 12 | Stream length in lines |
| wake_wr | input | 1 | Wakeup count write strobe |
| wake_lines | input | 16 | Wakeup count in requested lines |
| start | input | 1 | Start pulse |
| irq_clr | input | 1 | Clears the wakeup interrupt |
| buf_full | input | 1 | Request buffer has no room |
| req_valid | output | 1 | Line request pushed this cycle |
| req_addr | output | 32 | Line request byte address |
| req_stream | output | 2 | Stream of the request |
| busy | output | 1 | Engine running |
| wake_irq | output | 1 | Level wakeup interrupt |

## Verification
`req_valid`, `req_addr` and `req_stream` are combinational outputs. They are valid in the same cycle as the `buf_full` value that gates them, so the bench sets `buf_full` at the falling edge, waits one time step, and then samples them. `wake_irq` and `busy` change at the rising edge that accepts a request, so the bench compares them at the next falling edge against a running count of accepted requests. The buffer is modelled in the bench with a chosen depth and a drain of one line every 12 cycles. Runs with shallow depths force many stall cycles, and the bench checks that the request order stays unchanged.

// File: rtl/bulk_prefetch_engine.sv
module bulk_prefetch_engine #(
  parameter int STREAMS    = 4,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 12,
  parameter int WAKE_W     = 16,
  parameter int LINE_BYTES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_wr,
  input  logic [$clog2(STREAMS)-1:0] cfg_idx,
  input  logic [ADDR_W-1:0]          cfg_base,
  input  logic [LEN_W-1:0]           cfg_lines,
  input  logic                       wake_wr,
  input  logic [WAKE_W-1:0]          wake_lines,
  input  logic                       start,
  input  logic                       irq_clr,
  input  logic                       buf_full,
  output logic                       req_valid,
  output logic [ADDR_W-1:0]          req_addr,
  output logic [$clog2(STREAMS)-1:0] req_stream,
  output logic                       busy,
  output logic                       wake_irq
);
  localparam int SEL_W = $clog2(STREAMS);
  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam int TOT_W = LEN_W + SEL_W;

  logic [ADDR_W-1:0] base_q [STREAMS];
  logic [LEN_W-1:0]  left_q [STREAMS];
  logic [LEN_W-1:0]  idx_q  [STREAMS];
  logic [SEL_W-1:0]  rr_q, sel, sel_nxt;
  logic [TOT_W-1:0]  todo_q, total;
  logic              run_q, found, issue;
  logic [WAKE_W-1:0] wcnt_q, wtgt_q;
  logic              armed_q, irq_q;

  always_comb begin
    int c;
    found = 1'b0;
    sel   = '0;
    for (int k = 0; k < STREAMS; k++) begin
      c = (int'(rr_q) + k) % STREAMS;
      if (!found && left_q[c] != '0) begin
        found = 1'b1;
        sel   = SEL_W'(c);
      end
    end
    sel_nxt = SEL_W'((int'(sel) + 1) % STREAMS);
  end

  always_comb begin
    total = '0;
    for (int i = 0; i < STREAMS; i++) total = total + TOT_W'(left_q[i]);
  end

  assign issue      = run_q && found && !buf_full;
  assign req_valid  = issue;
  assign req_stream = sel;
  assign req_addr   = base_q[sel] + (ADDR_W'(idx_q[sel]) << OFS_W);
  assign busy       = run_q;
  assign wake_irq   = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STREAMS; i++) begin
        base_q[i] <= '0;
        left_q[i] <= '0;
        idx_q[i]  <= '0;
      end
      rr_q   <= '0;
      run_q  <= 1'b0;
      todo_q <= '0;
    end else begin
      if (cfg_wr && !run_q) begin
        base_q[cfg_idx] <= cfg_base;
        left_q[cfg_idx] <= cfg_lines;
        idx_q[cfg_idx]  <= '0;
      end
      if (start && !run_q) begin
        run_q  <= total != '0;
        todo_q <= total;
        rr_q   <= '0;
      end else if (issue) begin
        left_q[sel] <= left_q[sel] - LEN_W'(1);
        idx_q[sel]  <= idx_q[sel] + LEN_W'(1);
        rr_q        <= sel_nxt;
        todo_q      <= todo_q - TOT_W'(1);
        run_q       <= todo_q != TOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt_q  <= '0;
      wtgt_q  <= '0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (irq_clr) irq_q <= 1'b0;
      if (wake_wr) begin
        wcnt_q  <= '0;
        wtgt_q  <= wake_lines;
        armed_q <= wake_lines != '0;
      end else if (issue && armed_q) begin
        wcnt_q <= wcnt_q + WAKE_W'(1);
        if (wcnt_q + WAKE_W'(1) == wtgt_q) begin
          irq_q   <= 1'b1;
          armed_q <= 1'b0;
        end
      end
    end
  end

  p_busy_has_work_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> found);
  p_quiet_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start) |=> !req_valid);
  p_stall_keeps_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && buf_full && !start) |=> $stable(rr_q));
  p_irq_needs_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(issue));
  p_irq_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr) |=> irq_q);
  p_cfg_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !issue) |=> $stable(total));
endmodule

// File: tb/bulk_prefetch_engine_test.sv
module bulk_prefetch_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;

  logic        clk = 0, rst_n = 0;
  logic        cfg_wr = 0, wake_wr = 0, start = 0, irq_clr = 0, buf_full = 0;
  logic [1:0]  cfg_idx = 0;
  logic [31:0] cfg_base = 0;
  logic [11:0] cfg_lines = 0;
  logic [15:0] wake_lines = 0;
  logic        req_valid, busy, wake_irq;
  logic [31:0] req_addr;
  logic [1:0]  req_stream;

  int checks = 0, fails = 0, cyc = 0;

  bulk_prefetch_engine uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_stream(input int s, input logic [31:0] b, input int n);
    @(negedge clk);
    cfg_wr = 1; cfg_idx = 2'(s); cfg_base = b; cfg_lines = 12'(n);
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic run_case(input int l0, input int l1, input int l2, input int l3,
                          input int w, input int depth, input int hook_at, input int w2);
    int lens[NS];
    logic [31:0] bases[NS];
    int eleft[NS], eidx[NS];
    int ptr, acc, sum, fill, timer, cnt, tgt, guard, s;
    bit armed, eirq, acc_now, hooked, dowake;
    lens = '{l0, l1, l2, l3};
    sum = 0;
    for (int i = 0; i < NS; i++) begin
      bases[i] = 32'h1000_0000 * (i + 1) + 32'h40 * i;
      eleft[i] = lens[i]; eidx[i] = 0; sum += lens[i];
      write_stream(i, bases[i], lens[i]);
    end
    @(negedge clk);
    irq_clr = 1; wake_wr = 1; wake_lines = 16'(w);
    @(negedge clk);
    irq_clr = 0; wake_wr = 0;
    cnt = 0; tgt = w; armed = (w != 0); eirq = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == (sum != 0), "R6 busy after start", busy, sum != 0);
    ptr = 0; acc = 0; fill = 0; timer = 0; guard = 0; hooked = 0;
    while (acc < sum && guard < 20000) begin
      guard++;
      chk(wake_irq == eirq, "R7/R8 wake_irq level", wake_irq, eirq);
      chk(busy == 1'b1, "R6 busy while lines remain", busy, 1);
      timer++;
      if (timer == 12) begin timer = 0; if (fill > 0) fill--; end
      buf_full = (fill >= depth);
      dowake = 0;
      if (!hooked && hook_at >= 0 && acc >= hook_at) begin
        hooked = 1;
        cfg_wr = 1; cfg_idx = 1; cfg_base = 32'hDEAD_0000; cfg_lines = 12'd7;
        if (w2 >= 0) begin
          irq_clr = 1; wake_wr = 1; wake_lines = 16'(w2); dowake = 1;
        end
      end
      #1;
      acc_now = req_valid;
      if (buf_full) chk(!req_valid, "R3/R5 no request while full", req_valid, 0);
      else chk(req_valid, "R3 request when room", req_valid, 1);
      if (acc_now) begin
        s = -1;
        for (int k = 0; k < NS; k++)
          if (s < 0 && eleft[(ptr + k) % NS] > 0) s = (ptr + k) % NS;
        chk(req_stream == 2'(s), "R4/R5 rotation order", req_stream, s);
        chk(req_addr == bases[s] + 32'(eidx[s] * 16), "R2 line address",
            req_addr, bases[s] + 32'(eidx[s] * 16));
        eleft[s]--; eidx[s]++; ptr = (s + 1) % NS; acc++; fill++;
      end
      if (dowake) begin
        cnt = 0; tgt = w2; armed = (w2 != 0);
        eirq = 0;
      end else begin
        if (irq_clr) eirq = 0;
        if (acc_now && armed) begin
          cnt++;
          if (cnt == tgt) begin eirq = 1; armed = 0; end
        end
      end
      @(negedge clk);
      cfg_wr = 0; irq_clr = 0; wake_wr = 0;
    end
    buf_full = 0;
    for (int t = 0; t < 6; t++) begin
      #1;
      chk(!busy, "R6 busy low after last line", busy, 0);
      chk(!req_valid, "R6 no request after done", req_valid, 0);
      chk(wake_irq == eirq, "R7/R8 wake_irq after run", wake_irq, eirq);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!req_valid, "R1 req_valid in reset", req_valid, 0);
    chk(!busy, "R1 busy in reset", busy, 0);
    chk(!wake_irq, "R1 wake_irq in reset", wake_irq, 0);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(!req_valid && !busy && !wake_irq, "R1 idle after reset", {req_valid, busy, wake_irq}, 0);
    run_case(3, 0, 5, 2, 4, 4, 2, -1);
    run_case(1, 1, 1, 1, 0, 1, -1, -1);
    run_case(0, 6, 0, 0, 6, 2, -1, -1);
    run_case(0, 0, 0, 0, 1, 2, -1, -1);
    run_case(4, 4, 4, 4, 3, 3, 5, 2);
    run_case(2, 7, 1, 3, 13, 1, -1, -1);
    run_case(5, 1, 0, 4, 1, 2, 6, 9);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule